// File: doc/BRIEF.md
# Host bridge control register file

This block is the software-visible configuration bank of a host bridge. It holds twenty-eight 32-bit words on a word-addressed register bus. Most words are plain storage. The interrupt-enable word cannot be written directly. Software changes it through a pair of alias words: one sets the bits that are written as one, and the other clears them. The word that follows the enable word reflects the live interrupt-status input.

A synchronous reset loads fixed power-on values. The general configuration word also carries a soft-reset control. When software writes that bit from 0 to 1, the block emits a single-cycle system reset request.

All stored words are exposed side by side on a wide configuration output, so the bridge logic around the block can use them directly. Only full-word accesses are decoded. A byte offset that is not a multiple of four, or that lies past the last word, is treated as undecoded.

Top module: `hbr_ctl_regs`

## Requirements
- R1: While `rst` is high at a clock edge, every word loads its power-on value. The non-zero values are: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. All other words, the enable word and the reset request clear to zero.
- R2: A write to any plain word stores the full 32-bit value, and a later read of the same offset returns it. The plain words are offsets 0x00 to 0x2C and 0x40 to 0x6C, with 0x04 included.
- R3: A write to offset 0x30 stores the written value, which reads back at 0x30. The same write ORs the value into the enable word (offset 0x38, also on `irq_enable_o`), taking effect at that clock edge.
- R4: A write to offset 0x34 stores the written value, which reads back at 0x34. The same write clears in the enable word every bit that is one in the written value.
- R5: Writes to 0x38 and 0x3C change nothing. A read of 0x38 returns the enable word. A read of 0x3C returns `irq_status_i` as sampled at the read's clock edge.
- R6: An access is undecoded when the byte offset has bits [1:0] not equal to zero, or when the offset is above 0x6C. Writes to an undecoded offset change no state, and reads of one return zero.
- R7: A write to offset 0x04 with bit 2 of the stored word at 0 and bit 2 of the new value at 1 raises `sys_reset_req_o` for exactly the one cycle after that write's clock edge. No other write raises it, including a 1-to-1 write, a 1-to-0 write, or a write to a misaligned alias of 0x04.
- R8: `rd_data` is registered. It shows the addressed value in the cycle after a clock edge that sampled `rd_en` high, and zero after an edge that sampled `rd_en` low.
- R9: Word k of `cfg_o` (bits 32k+31 down to 32k) equals the value a read of offset 4k returns, for every k except 15. Word 15 (offset 0x3C) is zero, and word 14 is the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write value |
| rd_en | input | 1 | Read strobe |
| irq_status_i | input | DATA_W (32) | Live interrupt status, readable at 0x3C |
| rd_data | output | DATA_W (32) | Registered read value |
| irq_enable_o | output | DATA_W (32) | Interrupt enable word |
| cfg_o | output | 28*DATA_W (896) | All words, word k at bits 32k+31:32k |
| sys_reset_req_o | output | 1 | One-cycle soft-reset request |

## Verification
The first pass reads every word-aligned offset after reset. It separates the nine non-zero power-on values from the zero words and from the undecoded range.

The second pass writes every one of the 256 byte offsets, each with a value derived from its offset, and then reads all 256 back. This shows whether misaligned and out-of-range aliases leak into storage, and whether the read-only words and the alias words obey their own rules instead of plain storage. It also checks the enable word after every write.

Directed sequences then separate the four transitions of the soft-reset bit. They show the set and clear aliases acting on overlapping bit groups, and they confirm that the status word follows its input across several values.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   localparam int unsigned HBR_WORDS  = 28;
   localparam int unsigned IDX_GENCFG = 1;
   localparam int unsigned IDX_EN_SET = 12;
   localparam int unsigned IDX_EN_CLR = 13;
   localparam int unsigned IDX_EN_VAL = 14;
   localparam int unsigned IDX_STATUS = 15;

   typedef enum logic [2:0] {
      K_NONE,
      K_PLAIN,
      K_GENCFG,
      K_EN_SET,
      K_EN_CLR,
      K_READONLY
   } hbr_kind_e;

   function automatic logic [31:0] hbr_default(input int unsigned idx);
      case (idx)
         0:       return 32'h0000_0C40;
         1:       return 32'h0000_1384;
         2:       return 32'h2BFF_8010;
         3:       return 32'h255E_0091;
         4:       return 32'h0000_6140;
         7:       return 32'h0000_01FF;
         8:       return 32'h0000_01FF;
         26:      return 32'h0000_0008;
         27:      return 32'h1000_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic hbr_kind_e hbr_kind_of(input int unsigned idx);
      if (idx >= HBR_WORDS)                          return K_NONE;
      if (idx == IDX_GENCFG)                         return K_GENCFG;
      if (idx == IDX_EN_SET)                         return K_EN_SET;
      if (idx == IDX_EN_CLR)                         return K_EN_CLR;
      if (idx == IDX_EN_VAL || idx == IDX_STATUS)    return K_READONLY;
      return K_PLAIN;
   endfunction
endpackage

// File: rtl/hbr_addr_decode.sv
module hbr_addr_decode
   import hbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned IDX_W  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              hit,
   output hbr_kind_e         kind
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic              in_range;

   assign word     = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = (32'(word) < HBR_WORDS);
   assign hit      = aligned && in_range;
   assign idx      = word[IDX_W-1:0];
   assign kind     = hit ? hbr_kind_of(32'(word)) : K_NONE;
endmodule

// File: rtl/hbr_reg_bank.sv
module hbr_reg_bank
   import hbr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 5
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_stb,
   input  logic [IDX_W-1:0]            idx,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [HBR_WORDS*DATA_W-1:0] words_o
);
   for (genvar g = 0; g < HBR_WORDS; g++) begin : g_word
      if (g == IDX_EN_VAL || g == IDX_STATUS) begin : g_none
         assign words_o[g*DATA_W +: DATA_W] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= DATA_W'(hbr_default(g));
            else if (wr_stb && idx == IDX_W'(g))
               q <= wr_data;
         end
         assign words_o[g*DATA_W +: DATA_W] = q;
      end
   end
endmodule

// File: rtl/hbr_irq_enable.sv
module hbr_irq_enable #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_stb,
   input  logic              clr_stb,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] en_o
);
   always_ff @(posedge clk) begin
      if (rst)
         en_o <= '0;
      else if (set_stb)
         en_o <= en_o | mask;
      else if (clr_stb)
         en_o <= en_o & ~mask;
   end
endmodule

// File: rtl/hbr_reset_pulse.sv
module hbr_reset_pulse (
   input  logic clk,
   input  logic rst,
   input  logic cfg_wr,
   input  logic old_bit,
   input  logic new_bit,
   output logic pulse_o
);
   always_ff @(posedge clk) begin
      if (rst)
         pulse_o <= 1'b0;
      else
         pulse_o <= cfg_wr && !old_bit && new_bit;
   end
endmodule

// File: rtl/hbr_ctl_regs.sv
module hbr_ctl_regs
   import hbr_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned RST_BIT = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr_en,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        rd_en,
   input  logic [DATA_W-1:0]           irq_status_i,
   output logic [DATA_W-1:0]           rd_data,
   output logic [DATA_W-1:0]           irq_enable_o,
   output logic [HBR_WORDS*DATA_W-1:0] cfg_o,
   output logic                        sys_reset_req_o
);
   localparam int unsigned IDX_W = $clog2(HBR_WORDS);

   if (DATA_W < 32) begin : g_bad_data_w
      $error("hbr_ctl_regs: DATA_W must be at least 32");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr_w
      $error("hbr_ctl_regs: ADDR_W too small for the word count");
   end
   if (RST_BIT >= DATA_W) begin : g_bad_rst_bit
      $error("hbr_ctl_regs: RST_BIT outside the data word");
   end

   logic [IDX_W-1:0]            idx;
   logic                        hit;
   hbr_kind_e                   kind;
   logic [HBR_WORDS*DATA_W-1:0] bank_words;
   logic [DATA_W-1:0]           word_arr [HBR_WORDS];
   logic                        wr_hit;

   hbr_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
      .addr (addr),
      .idx  (idx),
      .hit  (hit),
      .kind (kind)
   );

   assign wr_hit = wr_en && hit;

   hbr_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_hit),
      .idx     (idx),
      .wr_data (wr_data),
      .words_o (bank_words)
   );

   hbr_irq_enable #(.DATA_W(DATA_W)) en_i (
      .clk     (clk),
      .rst     (rst),
      .set_stb (wr_en && kind == K_EN_SET),
      .clr_stb (wr_en && kind == K_EN_CLR),
      .mask    (wr_data),
      .en_o    (irq_enable_o)
   );

   hbr_reset_pulse rp_i (
      .clk     (clk),
      .rst     (rst),
      .cfg_wr  (wr_en && kind == K_GENCFG),
      .old_bit (bank_words[IDX_GENCFG*DATA_W + RST_BIT]),
      .new_bit (wr_data[RST_BIT]),
      .pulse_o (sys_reset_req_o)
   );

   always_comb begin
      cfg_o = bank_words;
      cfg_o[IDX_EN_VAL*DATA_W +: DATA_W] = irq_enable_o;
   end

   for (genvar g = 0; g < HBR_WORDS; g++) begin : g_arr
      assign word_arr[g] = cfg_o[g*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk) begin
      if (rst || !rd_en) begin
         rd_data <= '0;
      end else begin
         case (kind)
            K_NONE:     rd_data <= '0;
            K_READONLY: rd_data <= (32'(idx) == IDX_STATUS) ? irq_status_i : irq_enable_o;
            default:    rd_data <= word_arr[idx];
         endcase
      end
   end
endmodule

// File: rtl/hbr_ctl_regs_chk.sv
module hbr_ctl_regs_chk
   import hbr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic                        clk,
   input logic                        rst,
   input logic [ADDR_W-1:0]           addr,
   input logic                        wr_en,
   input logic [DATA_W-1:0]           wr_data,
   input logic                        rd_en,
   input logic [DATA_W-1:0]           irq_status_i,
   input logic [DATA_W-1:0]           rd_data,
   input logic [DATA_W-1:0]           irq_enable_o,
   input logic [HBR_WORDS*DATA_W-1:0] cfg_o,
   input logic                        sys_reset_req_o
);
   logic undecoded;
   logic at_set, at_clr, at_gen;

   assign undecoded = (addr[1:0] != 2'b00) || (32'(addr[ADDR_W-1:2]) >= HBR_WORDS);
   assign at_set    = (addr == ADDR_W'(8'h30));
   assign at_clr    = (addr == ADDR_W'(8'h34));
   assign at_gen    = (addr == ADDR_W'(8'h04));

   assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && at_set) |=> ((irq_enable_o & $past(wr_data)) == $past(wr_data)));

   assert_en_clr_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && at_clr) |=> ((irq_enable_o & $past(wr_data)) == '0));

   assert_en_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (at_set || at_clr)) |=> $stable(irq_enable_o));

   assert_undec_read_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && undecoded) |=> (rd_data == '0));

   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
      sys_reset_req_o |=> !sys_reset_req_o);

   assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(sys_reset_req_o) |-> $past(wr_en && at_gen && wr_data[2]));

   assert_idle_read_R8: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> (rd_data == '0));
endmodule

bind hbr_ctl_regs hbr_ctl_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk             (clk),
   .rst             (rst),
   .addr            (addr),
   .wr_en           (wr_en),
   .wr_data         (wr_data),
   .rd_en           (rd_en),
   .irq_status_i    (irq_status_i),
   .rd_data         (rd_data),
   .irq_enable_o    (irq_enable_o),
   .cfg_o           (cfg_o),
   .sys_reset_req_o (sys_reset_req_o)
);

// File: tb/hbr_ctl_regs_tb_top.sv
module hbr_ctl_regs_tb_top;
   localparam int NW = 28;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [7:0]        addr = '0;
   logic              wr_en = 1'b0;
   logic [31:0]       wr_data = '0;
   logic              rd_en = 1'b0;
   logic [31:0]       irq_status_i = 32'hA5A5_0F0F;
   logic [31:0]       rd_data;
   logic [31:0]       irq_enable_o;
   logic [NW*32-1:0]  cfg_o;
   logic              sys_reset_req_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [31:0] m [NW];
   logic [31:0] men;

   always #2 clk = ~clk;

   hbr_ctl_regs dut_i (
      .clk (clk), .rst (rst), .addr (addr), .wr_en (wr_en), .wr_data (wr_data),
      .rd_en (rd_en), .irq_status_i (irq_status_i), .rd_data (rd_data),
      .irq_enable_o (irq_enable_o), .cfg_o (cfg_o), .sys_reset_req_o (sys_reset_req_o)
   );

   function automatic logic [31:0] exp_default(input int i);
      case (i)
         0: return 32'hC40;        1: return 32'h1384;
         2: return 32'h2BFF8010;   3: return 32'h255E0091;
         4: return 32'h6140;       7: return 32'h1FF;
         8: return 32'h1FF;        26: return 32'h8;
         27: return 32'h10000000;  default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NW; i++) m[i] = exp_default(i);
      men = '0;
   endtask

   function automatic bit undec(input logic [7:0] a);
      return (a[1:0] != 2'b00) || (int'(a[7:2]) >= NW);
   endfunction

   task automatic model_wr(input logic [7:0] a, input logic [31:0] d, output bit pulse);
      int w;
      pulse = 1'b0;
      w = int'(a[7:2]);
      if (!undec(a)) begin
         case (w)
            1:  begin pulse = !m[1][2] && d[2]; m[1] = d; end
            12: begin m[12] = d; men = men | d; end
            13: begin m[13] = d; men = men & ~d; end
            14, 15: ;
            default: m[w] = d;
         endcase
      end
   endtask

   function automatic logic [31:0] model_rd(input logic [7:0] a);
      int w;
      w = int'(a[7:2]);
      if (undec(a)) return 32'h0;
      if (w == 14) return men;
      if (w == 15) return irq_status_i;
      return m[w];
   endfunction

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic wr_and_check(input logic [7:0] a, input logic [31:0] d);
      bit ep;
      model_wr(a, d, ep);
      do_write(a, d);
      chk("R7", $sformatf("pulse after write %h", a), {31'b0, sys_reset_req_o}, {31'b0, ep});
      chk("R3", $sformatf("enable after write %h", a), irq_enable_o, men);
      @(negedge clk);
      chk("R7", "pulse gone next cycle", {31'b0, sys_reset_req_o}, 32'h0);
   endtask

   task automatic read_check(input string req, input logic [7:0] a);
      logic [31:0] v;
      do_read(a, v);
      chk(req, $sformatf("read %h", a), v, model_rd(a));
   endtask

   task automatic cfg_check();
      for (int k = 0; k < NW; k++)
         chk("R9", $sformatf("cfg word %0d", k), cfg_o[k*32 +: 32], (k == 15) ? 32'h0 : model_rd(8'(k*4)));
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      #800000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      apply_reset();
      // R1 / R8: state right after reset
      chk("R1", "enable at reset", irq_enable_o, 32'h0);
      chk("R1", "reset request at reset", {31'b0, sys_reset_req_o}, 32'h0);
      chk("R8", "rd_data idle after reset", rd_data, 32'h0);

      // R1 / R6: every aligned offset after reset
      for (int w = 0; w < 64; w++) read_check((w < NW) ? "R1" : "R6", 8'(w*4));
      cfg_check();

      // R2 / R6 / R3 / R4 / R5: write sweep over all byte offsets
      for (int a = 0; a < 256; a++) begin
         logic [7:0] b;
         b = 8'(a);
         wr_and_check(b, {b, ~b, b ^ 8'h3C, 8'(b * 8'd7)});
      end
      for (int a = 0; a < 256; a++) read_check(undec(8'(a)) ? "R6" : "R2", 8'(a));
      cfg_check();

      // R7: soft-reset bit transitions
      wr_and_check(8'h04, 32'h0000_0000);   // 1/0 -> 0: whatever came before
      wr_and_check(8'h04, 32'h0000_0000);   // 0 -> 0
      wr_and_check(8'h04, 32'h0000_0004);   // 0 -> 1 pulse
      wr_and_check(8'h04, 32'h0000_0004);   // 1 -> 1
      wr_and_check(8'h04, 32'h0000_0000);   // 1 -> 0
      wr_and_check(8'h05, 32'hFFFF_FFFF);   // misaligned alias
      wr_and_check(8'h04, 32'hFFFF_FFFF);   // 0 -> 1 pulse
      read_check("R7", 8'h04);

      // R3 / R4 / R5: enable aliases on overlapping groups
      wr_and_check(8'h34, 32'hFFFF_FFFF);
      chk("R4", "enable cleared", irq_enable_o, 32'h0);
      wr_and_check(8'h30, 32'h0000_00F0);
      wr_and_check(8'h30, 32'h0000_000F);
      chk("R3", "enable set twice", irq_enable_o, 32'h0000_00FF);
      wr_and_check(8'h34, 32'h0000_003C);
      chk("R4", "enable partial clear", irq_enable_o, 32'h0000_00C3);
      wr_and_check(8'h38, 32'hFFFF_0000);
      chk("R5", "enable write ignored", irq_enable_o, 32'h0000_00C3);
      read_check("R3", 8'h30);
      read_check("R4", 8'h34);
      read_check("R5", 8'h38);

      // R5: status is live
      wr_and_check(8'h3C, 32'h1234_5678);
      irq_status_i = 32'h0000_0000; read_check("R5", 8'h3C);
      irq_status_i = 32'hFFFF_FFFF; read_check("R5", 8'h3C);
      irq_status_i = 32'h8000_0001; read_check("R5", 8'h3C);

      // R8: idle cycle returns zero
      @(negedge clk);
      chk("R8", "rd_data after idle", rd_data, 32'h0);
      cfg_check();

      // R1: reset in the middle restores defaults
      apply_reset();
      for (int w = 0; w < NW; w++) read_check("R1", 8'(w*4));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule